// File: doc/BRIEF.md
# Bus Address Map Register File

This block keeps the table of mapping registers that stretches 18-bit peripheral bus addresses into a 22-bit physical space. It holds 31 entries of 22 bits. The I/O front end sees them as 62 consecutive 16-bit words in the I/O page, starting at byte offset 010200 octal (0x1080). Each entry takes two words. The word at the lower address carries entry bits 15:0, with bit 0 always zero. The word two bytes above it carries entry bits 21:16 in its six low bits.

The front end presents one access per cycle as a byte offset within the I/O page. A read returns the addressed word combinationally. A word write updates only the addressed half of an entry, on the next clock edge. A byte write is carried out as a read of the containing word, a merge of the new byte, and a write of the whole word, all in the same cycle. A separate lookup port serves the translation logic: it takes a 5-bit entry index and returns the full 22-bit base at once.

Top module: `busmap_regfile`

## Requirements
- R1: While `rst_n` is low, and after it rises, every entry is zero. A lookup of any index and a read of any window word return 0 until that entry is written.
- R2: `acc_hit` is 1 exactly when `acc_en` is 1 and `acc_off` lies in 0x1080..0x10FB. The entry index is (acc_off - 0x1080) >> 2. Offset bit 1 selects the word: 0 is the low word, 1 is the high word. Offset bit 0 is ignored for word accesses. Outside the window a write changes nothing and `acc_rdata` is 0.
- R3: A read of a low word returns entry bits 15:0.
- R4: A read of a high word returns entry bits 21:16 in bits 5:0, and zero in bits 15:6.
- R5: A word write to a low word stores `acc_wdata` bits 15:1 into entry bits 15:1 and stores 0 in bit 0. Entry bits 21:16 keep their value.
- R6: A word write to a high word stores `acc_wdata` bits 5:0 into entry bits 21:16. Entry bits 15:0 keep their value.
- R7: For a byte write (`acc_byte`=1), the new byte is `acc_wdata` bits 7:0. Offset bit 0 selects the lane: 0 replaces bits 7:0 of the addressed word and 1 replaces bits 15:8, and the other byte is taken from a read of that word. The merged word is then written under R5 or R6. A byte write to the upper lane of a high word therefore leaves the entry unchanged.
- R8: A pulse on `bus_rst_cyc` leaves every entry unchanged.
- R9: `lk_base` returns entry `lk_idx` combinationally. Index 31 returns zero.
- R10: `acc_rdata` and `lk_base` show a write only after the clock edge at which it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low; clears all entries |
| acc_en | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | Byte write (lane chosen by acc_off[0]) |
| acc_off | input | 13 | Byte offset within the I/O page |
| acc_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rst_cyc | input | 1 | Bus reset cycle; has no effect on the table |
| acc_rdata | output | 16 | Read data of the addressed word, 0 on a miss |
| acc_hit | output | 1 | Access falls inside the map window |
| lk_idx | input | 5 | Lookup entry index |
| lk_base | output | 22 | 22-bit base of the looked-up entry |

## Verification
The assertions check on every cycle that a miss reads zero and that a high word never shows bits above bit 5. They also check that a low word always reads with bit 0 clear and that index 31 looks up as zero. In addition, they check that a half-word write, or a bus reset cycle, leaves the other half of the looked-up entry untouched. Only the bench's scenarios can show the actual stored values: the bit-0 forcing on real data, the byte-lane merge including the no-effect upper lane of a high word, the window edges, and the one-cycle delay before a write becomes visible.

// File: rtl/busmap_pkg.sv
package busmap_pkg;
  localparam int BM_WORD_W = 16;
  localparam int BM_ENT_W  = 22;
  localparam int BM_HI_W   = BM_ENT_W - BM_WORD_W;

  typedef logic [BM_WORD_W-1:0] bm_word_t;
  typedef logic [BM_ENT_W-1:0]  bm_entry_t;

  // word seen by the bus for one half of an entry
  function automatic bm_word_t bm_half_read(input bm_entry_t ent, input logic hi);
    bm_word_t w;
    if (hi) w = {{(BM_WORD_W-BM_HI_W){1'b0}}, ent[BM_ENT_W-1:BM_WORD_W]};
    else    w = ent[BM_WORD_W-1:0];
    return w;
  endfunction

  // replace one byte lane of the current word
  function automatic bm_word_t bm_lane_merge(input bm_word_t cur, input logic [7:0] b,
                                             input logic upper);
    bm_word_t w;
    if (upper) w = {b, cur[7:0]};
    else       w = {cur[15:8], b};
    return w;
  endfunction

  // fold a full word into the chosen half of an entry
  function automatic bm_entry_t bm_half_write(input bm_entry_t ent, input logic hi,
                                              input bm_word_t w);
    bm_entry_t e;
    if (hi) e = {w[BM_HI_W-1:0], ent[BM_WORD_W-1:0]};
    else    e = {ent[BM_ENT_W-1:BM_WORD_W], w[BM_WORD_W-1:1], 1'b0};
    return e;
  endfunction
endpackage

// File: rtl/busmap_decode.sv
module busmap_decode #(
  parameter int OFF_W    = 13,
  parameter int N_ENTRY  = 31,
  parameter int WIN_BASE = 'h1080,
  parameter int IDX_W    = 5
) (
  input  logic             en,
  input  logic [OFF_W-1:0] off,
  output logic             hit,
  output logic             hi_sel,
  output logic             lane_up,
  output logic [IDX_W-1:0] idx
);
  localparam int WIN_BYTES = 4 * N_ENTRY;
  localparam logic [OFF_W-1:0] BASE_V = OFF_W'(WIN_BASE);
  localparam logic [OFF_W-1:0] SPAN_V = OFF_W'(WIN_BYTES);

  logic [OFF_W-1:0] rel;
  logic             above;

  always_comb begin
    rel     = off - BASE_V;
    above   = (off >= BASE_V);
    hit     = en && above && (rel < SPAN_V);
    hi_sel  = rel[1];
    lane_up = off[0];
    idx     = rel[IDX_W+1:2];
  end
endmodule

// File: rtl/busmap_merge.sv
module busmap_merge
  import busmap_pkg::*;
(
  input  bm_entry_t   cur_ent,
  input  logic        hi_sel,
  input  logic        byte_mode,
  input  logic        lane_up,
  input  bm_word_t    wdata,
  output bm_word_t    rd_word,
  output bm_entry_t   nxt_ent
);
  bm_word_t full_word;

  always_comb begin
    rd_word = bm_half_read(cur_ent, hi_sel);
    if (byte_mode) full_word = bm_lane_merge(rd_word, wdata[7:0], lane_up);
    else           full_word = wdata;
    nxt_ent = bm_half_write(cur_ent, hi_sel, full_word);
  end
endmodule

// File: rtl/busmap_store.sv
module busmap_store
  import busmap_pkg::*;
#(
  parameter int N_ENTRY = 31,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] wr_idx,
  input  bm_entry_t        wr_ent,
  input  logic [IDX_W-1:0] acc_idx,
  output bm_entry_t        acc_ent,
  input  logic [IDX_W-1:0] lk_idx,
  output bm_entry_t        lk_ent
);
  bm_entry_t ent_q [N_ENTRY];

  for (genvar gi = 0; gi < N_ENTRY; gi++) begin : g_ent
    logic sel;
    assign sel = wr_fire && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[gi] <= '0;
      else if (sel) ent_q[gi] <= wr_ent;
    end
  end

  always_comb begin
    acc_ent = '0;
    lk_ent  = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (acc_idx == IDX_W'(i)) acc_ent = ent_q[i];
      if (lk_idx  == IDX_W'(i)) lk_ent  = ent_q[i];
    end
  end
endmodule

// File: rtl/busmap_regfile.sv
module busmap_regfile
  import busmap_pkg::*;
#(
  parameter int OFF_W    = 13,
  parameter int N_ENTRY  = 31,
  parameter int WIN_BASE = 'h1080,
  localparam int IDX_W   = $clog2(N_ENTRY + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic                 acc_byte,
  input  logic [OFF_W-1:0]     acc_off,
  input  logic [BM_WORD_W-1:0] acc_wdata,
  input  logic                 bus_rst_cyc,
  output logic [BM_WORD_W-1:0] acc_rdata,
  output logic                 acc_hit,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic [BM_ENT_W-1:0]  lk_base
);
  // named internal events, observed by the checker
  logic             dec_hi;
  logic             dec_lane_up;
  logic [IDX_W-1:0] dec_idx;
  logic             wr_fire;
  logic             bus_rst_seen;
  bm_entry_t        cur_ent;
  bm_entry_t        nxt_ent;
  bm_word_t         rd_word;

  busmap_decode #(
    .OFF_W(OFF_W), .N_ENTRY(N_ENTRY), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .en(acc_en), .off(acc_off), .hit(acc_hit), .hi_sel(dec_hi),
    .lane_up(dec_lane_up), .idx(dec_idx)
  );

  busmap_merge u_mrg (
    .cur_ent(cur_ent), .hi_sel(dec_hi), .byte_mode(acc_byte),
    .lane_up(dec_lane_up), .wdata(acc_wdata), .rd_word(rd_word), .nxt_ent(nxt_ent)
  );

  busmap_store #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(dec_idx),
    .wr_ent(nxt_ent), .acc_idx(dec_idx), .acc_ent(cur_ent),
    .lk_idx(lk_idx), .lk_ent(lk_base)
  );

  // a bus reset cycle is accepted and deliberately does nothing to the table
  assign bus_rst_seen = bus_rst_cyc;
  assign wr_fire      = acc_hit && acc_wr;
  assign acc_rdata    = acc_hit ? rd_word : '0;
endmodule

// File: rtl/busmap_checker.sv
module busmap_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_hit,
  input logic             acc_wr,
  input logic             dec_hi,
  input logic [IDX_W-1:0] dec_idx,
  input logic             wr_fire,
  input logic             bus_rst_seen,
  input logic [15:0]      acc_rdata,
  input logic [IDX_W-1:0] lk_idx,
  input logic [21:0]      lk_base
);
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> acc_rdata == 16'h0);                                      // R2
  AST_LOW_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && !dec_hi && !acc_wr) |-> !acc_rdata[0]);                     // R5
  AST_HIGH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && dec_hi) |-> acc_rdata[15:6] == 10'h0);                      // R4
  AST_LOOKUP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_idx == {IDX_W{1'b1}}) |-> lk_base == 22'h0);                        // R9
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && dec_hi && lk_idx == dec_idx) |=>
      ($stable(lk_idx) |-> lk_base[15:0] == $past(lk_base[15:0])));         // R6
  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !dec_hi && lk_idx == dec_idx) |=>
      ($stable(lk_idx) |-> lk_base[21:16] == $past(lk_base[21:16])));       // R5
  AST_BUS_RESET_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_seen && !wr_fire) |=> ($stable(lk_idx) |-> $stable(lk_base))); // R8
endmodule

bind busmap_regfile busmap_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .acc_wr(acc_wr), .dec_hi(dec_hi),
  .dec_idx(dec_idx), .wr_fire(wr_fire), .bus_rst_seen(bus_rst_seen),
  .acc_rdata(acc_rdata), .lk_idx(lk_idx), .lk_base(lk_base)
);

// File: tb/busmap_regfile_bench.sv
module busmap_regfile_bench;
  localparam int PERIOD = 10;
  localparam int NV = 29;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_byte = 1'b0, bus_rst_cyc = 1'b0;
  logic [12:0] acc_off = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic        acc_hit;
  logic [4:0]  lk_idx = '0;
  logic [21:0] lk_base;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  busmap_regfile u_busmap_regfile (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_byte(acc_byte),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .bus_rst_cyc(bus_rst_cyc),
    .acc_rdata(acc_rdata), .acc_hit(acc_hit), .lk_idx(lk_idx), .lk_base(lk_base)
  );

  // vector: {wr, byte, req[3:0], off[12:0], wdata[15:0], expected read[15:0]}
  // entry k: low word at 0x1080 + 4k, high word at 0x1082 + 4k
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,1'b0,4'd1, 13'h1080,16'h0000,16'h0000}, // R1 empty after reset
    {1'b1,1'b0,4'd5, 13'h1080,16'hFFFF,16'h0000}, // R5 low write
    {1'b0,1'b0,4'd5, 13'h1080,16'h0000,16'hFFFE}, // R5 bit0 forced
    {1'b0,1'b0,4'd5, 13'h1082,16'h0000,16'h0000}, // R5 high untouched
    {1'b1,1'b0,4'd6, 13'h1082,16'hFFFF,16'h0000}, // R6 high write
    {1'b0,1'b0,4'd4, 13'h1082,16'h0000,16'h003F}, // R4 six bits only
    {1'b0,1'b0,4'd6, 13'h1080,16'h0000,16'hFFFE}, // R6 low kept
    {1'b1,1'b0,4'd5, 13'h1080,16'h1235,16'h0000},
    {1'b0,1'b0,4'd3, 13'h1080,16'h0000,16'h1234}, // R3 low read
    {1'b0,1'b0,4'd5, 13'h1082,16'h0000,16'h003F}, // R5 high kept
    {1'b1,1'b0,4'd2, 13'h10FA,16'h0015,16'h0000}, // R2 last entry high
    {1'b0,1'b0,4'd2, 13'h10FA,16'h0000,16'h0015},
    {1'b1,1'b0,4'd2, 13'h10FC,16'hFFFF,16'h0000}, // R2 just above window
    {1'b0,1'b0,4'd2, 13'h10FC,16'h0000,16'h0000},
    {1'b1,1'b0,4'd2, 13'h107E,16'hFFFF,16'h0000}, // R2 just below window
    {1'b0,1'b0,4'd2, 13'h107E,16'h0000,16'h0000},
    {1'b1,1'b0,4'd7, 13'h1084,16'hA5C2,16'h0000},
    {1'b1,1'b1,4'd7, 13'h1084,16'hFF77,16'h0000}, // R7 low lane, bit0 forced
    {1'b0,1'b0,4'd7, 13'h1084,16'h0000,16'hA576},
    {1'b1,1'b1,4'd7, 13'h1085,16'h003C,16'h0000}, // R7 upper lane
    {1'b0,1'b0,4'd7, 13'h1084,16'h0000,16'h3C76},
    {1'b1,1'b1,4'd7, 13'h1086,16'h00FF,16'h0000}, // R7 high word low lane
    {1'b0,1'b0,4'd7, 13'h1086,16'h0000,16'h003F},
    {1'b1,1'b1,4'd7, 13'h1087,16'h00FF,16'h0000}, // R7 high upper lane: no effect
    {1'b0,1'b0,4'd7, 13'h1086,16'h0000,16'h003F},
    {1'b1,1'b1,4'd7, 13'h1086,16'h0012,16'h0000},
    {1'b0,1'b0,4'd7, 13'h1084,16'h0000,16'h3C76},
    {1'b1,1'b0,4'd2, 13'h1081,16'h4444,16'h0000}, // R2 odd word offset
    {1'b0,1'b0,4'd2, 13'h1080,16'h0000,16'h4444}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic bm, input logic [12:0] off,
                        input logic [15:0] wd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_byte = bm; acc_off = off; acc_wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_byte = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    lk_idx = 5'd7; #1;
    check("R1 lookup in reset", 32'(lk_base), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][50], VEC[i][49], VEC[i][44:32], VEC[i][31:16]);
      if (!VEC[i][50]) check($sformatf("R%0d vec%0d", VEC[i][48:45], i),
                             32'(acc_rdata), 32'(VEC[i][15:0]));
    end
    idle();

    // R2 hit flag at both window edges
    access(1'b0, 1'b0, 13'h10FB, 16'h0); check("R2 hit top", 32'(acc_hit), 32'h1);
    access(1'b0, 1'b0, 13'h10FC, 16'h0); check("R2 miss top", 32'(acc_hit), 32'h0);
    access(1'b0, 1'b0, 13'h1080, 16'h0); check("R2 hit base", 32'(acc_hit), 32'h1);
    @(negedge clk); acc_en = 1'b0; #1;
    check("R2 no enable", 32'(acc_hit), 32'h0);

    // R9 lookups
    idle();
    lk_idx = 5'd0;  #1; check("R9 idx0", 32'(lk_base), 32'h3F4444);
    lk_idx = 5'd1;  #1; check("R9 idx1", 32'(lk_base), 32'h123C76);
    lk_idx = 5'd30; #1; check("R9 idx30", 32'(lk_base), 32'h150000);
    lk_idx = 5'd31; #1; check("R9 idx31", 32'(lk_base), 32'h0);

    // R10 write visible only after the edge
    access(1'b1, 1'b0, 13'h1088, 16'h0100);
    lk_idx = 5'd2; #1;
    check("R10 before edge", 32'(acc_rdata), 32'h0);
    @(posedge clk); #1;
    check("R10 after edge", 32'(acc_rdata), 32'h0100);
    check("R10 lookup", 32'(lk_base), 32'h000100);
    idle();

    // R8 bus reset cycle is inert
    lk_idx = 5'd0;
    @(negedge clk); bus_rst_cyc = 1'b1;
    repeat (2) @(negedge clk);
    bus_rst_cyc = 1'b0; #1;
    check("R8 entry0 kept", 32'(lk_base), 32'h3F4444);
    access(1'b0, 1'b0, 13'h1086, 16'h0);
    check("R8 entry1 high kept", 32'(acc_rdata), 32'h0012);
    idle();

    // R1 hard reset clears
    rst_n = 1'b0; #1;
    check("R1 lookup cleared", 32'(lk_base), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 1'b0, 13'h1086, 16'h0);
    check("R1 read cleared", 32'(acc_rdata), 32'h0);
    idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule